// File: doc/BRIEF.md
# Timer with Buffered Reload, Prescale and Compare Values

This block is a general-purpose timer. A prescaler divides an enabled clock. An up/down counter steps once per prescaler period and wraps at a programmable reload bound. Four compare channels each give a one-clock pulse when the counter steps onto their value. Software writes every programmable value into a visible holding register. The counting logic only ever uses a hidden working copy of that value, and software cannot read the working copy.

Each register has its own rule for when the working copy picks up a new value. For the reload bound and for each compare channel, a buffer-enable bit chooses between two cases. With the bit clear, a write reaches the working copy at once. With the bit set, the working copy waits for the next update event. The prescale divisor is always buffered. An update event happens when the counter wraps, or when software writes the control register with the force-update bit set. Each update event gives a one-clock pulse on `upd_evt`.

Register map (address, meaning):
0 is control. Bit 0 is run. Bit 1 is reload buffer enable. Bits 2..5 are the buffer enables for compare channels 0..3. Bit 6 is force update; it acts on write and reads back as 0.
1 is reload. 2 is prescale divisor. 3 is the counter, which is read-only. 4..7 are compare channels 0..3.

Top module: `buf_timer`

## Requirements
- R1: After reset, every readable register reads 0, `upd_evt` and `cmp_hit` are low, and the counter stays at 0 while control bit 0 (run) is clear.
- R2: The counter moves one step for every (working divisor + 1) clocks in which run is 1 and `tick_en` is 1. If either is 0, the counter and the prescaler hold.
- R3: When `dir_down` is 0, the counter steps up. On a step from the working reload value, it goes to 0 and `upd_evt` is high for one clock. From reload value N with divisor 0, pulses come every N+1 clocks.
- R4: When `dir_down` is 1, the counter steps down. On a step from 0, it loads the working reload value and `upd_evt` pulses. From reload value N with divisor 0, pulses come every N+1 clocks.
- R5: With control bit 1 at 0, a write to address 1 changes the working reload value in the same clock.
- R6: With control bit 1 at 1, a write to address 1 leaves the working reload value unchanged until the next update event.
- R7: A write to address 2 never reaches the working divisor before the next update event, whatever the control bits are.
- R8: Channel i (address 4+i, buffer enable at control bit 2+i) drives `cmp_hit[i]` high for one clock when a counter step lands on its working compare value. Its buffer enable has the same effect that bit 1 has for the reload value.
- R9: Writing control with bit 6 set causes four things in the next clock. The prescaler restarts. The counter becomes 0 (up) or the new working reload value (down). Every working copy takes its holding value. `upd_evt` pulses.
- R10: Reads of addresses 0, 1, 2 and 4..7 return the value last written, not the working copy. Control bit 6 reads 0. Address 3 returns the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Read data for `reg_addr`, combinational |
| tick_en | input | 1 | Clock enable for the prescaler |
| dir_down | input | 1 | 1 = count down, 0 = count up |
| upd_evt | output | 1 | One-clock pulse per update event |
| cmp_hit | output | NUM_CH (4) | One-clock compare-match pulses |

## Verification
The assertions check several properties on every clock:
- When stepping is disabled and no forced update arrives, the counter holds.
- Every update pulse leaves the counter at 0 or at the working reload value.
- A buffered reload working copy and the divisor working copy change only on an update.
- A compare pulse always coincides with the counter equal to that channel's working value.
- A forced update is always followed by a pulse.

Some behaviour can only be shown by the directed scenarios, because it depends on what software wrote and when. This covers the exact pulse spacing for a given bound and divisor. It also covers whether a write issued mid-period takes effect in the current period or the next one, the counter value at which a buffered compare fires before and after an update, and readback of holding registers.

// File: rtl/buf_timer_pkg.sv
package buf_timer_pkg;
   // register addresses
   localparam int unsigned ADR_CTRL     = 0;
   localparam int unsigned ADR_RELOAD   = 1;
   localparam int unsigned ADR_PRESC    = 2;
   localparam int unsigned ADR_COUNT    = 3;
   localparam int unsigned ADR_CMP_BASE = 4;

   // control register bit positions
   localparam int unsigned CB_RUN     = 0;
   localparam int unsigned CB_RLD_BUF = 1;
   localparam int unsigned CB_CH_BUF  = 2;

   typedef enum logic {
      STEP_UP   = 1'b0,
      STEP_DOWN = 1'b1
   } step_dir_e;
endpackage

// File: rtl/buf_timer_shadow.sv
// Holding register plus hidden working copy. ALWAYS_BUF selects a copy that
// only moves on update events; otherwise buf_en chooses per write.
module buf_timer_shadow #(
   parameter int unsigned W          = 16,
   parameter bit          ALWAYS_BUF = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         buf_en,
   input  logic         upd_now,
   output logic [W-1:0] pre_q,
   output logic [W-1:0] sh_q,
   output logic [W-1:0] sh_next
);
   if (W < 1) begin : g_bad_w
      $error("buf_timer_shadow: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pre_q <= '0;
      else if (wr_en) pre_q <= wr_data;
   end

   if (ALWAYS_BUF) begin : g_locked
      logic buf_en_unused;
      assign buf_en_unused = buf_en;
      assign sh_next = upd_now ? pre_q : sh_q;
   end else begin : g_select
      always_comb begin
         if (wr_en && !buf_en) sh_next = wr_data;
         else if (upd_now)     sh_next = pre_q;
         else                  sh_next = sh_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_next;
   end
endmodule

// File: rtl/buf_timer_prescaler.sv
// Divides enabled clocks by (div_sh + 1); adv marks the clock a step occurs.
module buf_timer_prescaler #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_en,
   input  logic         clr,
   input  logic [W-1:0] div_sh,
   output logic         adv
);
   if (W < 1) begin : g_bad_w
      $error("buf_timer_prescaler: W must be at least 1");
   end

   logic [W-1:0] pc_q;

   assign adv = step_en && !clr && (pc_q == div_sh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pc_q <= '0;
      else if (clr)     pc_q <= '0;
      else if (step_en) pc_q <= adv ? '0 : pc_q + 1'b1;
   end
endmodule

// File: rtl/buf_timer_counter.sv
// Up/down counter. Up wraps past the current bound; down reloads with the
// bound that is valid after this edge (new working copy on an update).
module buf_timer_counter
   import buf_timer_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic         dir_down,
   input  logic         clr,
   input  logic [W-1:0] lim,
   input  logic [W-1:0] lim_next,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] cnt_next,
   output logic         wrap
);
   if (W < 2) begin : g_bad_w
      $error("buf_timer_counter: W must be at least 2");
   end

   step_dir_e dir;
   assign dir  = step_dir_e'(dir_down);
   assign wrap = adv && ((dir == STEP_DOWN) ? (cnt_q == '0) : (cnt_q == lim));

   always_comb begin
      cnt_next = cnt_q;
      if (clr) begin
         cnt_next = (dir == STEP_DOWN) ? lim_next : '0;
      end else if (adv) begin
         if (dir == STEP_DOWN) cnt_next = wrap ? lim_next : cnt_q - 1'b1;
         else                  cnt_next = wrap ? '0 : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_next;
   end
endmodule

// File: rtl/buf_timer.sv
module buf_timer
   import buf_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PSC_W  = 16,
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tick_en,
   input  logic              dir_down,
   output logic              upd_evt,
   output logic [NUM_CH-1:0] cmp_hit
);
   localparam int unsigned CTRL_W    = CB_CH_BUF + NUM_CH;
   localparam int unsigned FORCE_BIT = CTRL_W;
   localparam int unsigned NUM_ADR   = ADR_CMP_BASE + NUM_CH;

   if (CNT_W > DATA_W || PSC_W > DATA_W) begin : g_bad_width
      $error("buf_timer: counter and prescale widths must fit the data bus");
   end
   if (FORCE_BIT >= DATA_W) begin : g_bad_ctrl
      $error("buf_timer: control bits do not fit the data bus");
   end
   if (NUM_ADR > (1 << ADDR_W)) begin : g_bad_addr
      $error("buf_timer: address width too small for channel count");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("buf_timer: at least one compare channel is needed");
   end

   // ---------------- control register and strobes ----------------
   logic [CTRL_W-1:0] ctrl_q;
   logic              run, arb;
   logic [NUM_CH-1:0] chb;
   logic              wr_ctrl, wr_reload, wr_presc, ug_req;

   assign run = ctrl_q[CB_RUN];
   assign arb = ctrl_q[CB_RLD_BUF];
   assign chb = ctrl_q[CB_CH_BUF +: NUM_CH];

   assign wr_ctrl   = reg_we && (reg_addr == ADDR_W'(ADR_CTRL));
   assign wr_reload = reg_we && (reg_addr == ADDR_W'(ADR_RELOAD));
   assign wr_presc  = reg_we && (reg_addr == ADDR_W'(ADR_PRESC));
   assign ug_req    = wr_ctrl && reg_wdata[FORCE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
   end

   // ---------------- reload and prescale holding/working pairs ----------------
   logic             upd_now, wrap, adv;
   logic [CNT_W-1:0] arr_pre, arr_sh, arr_sh_next;
   logic [PSC_W-1:0] psc_pre, psc_sh, psc_next_unused;
   logic [CNT_W-1:0] cnt_q, cnt_next;

   assign upd_now = ug_req || wrap;

   buf_timer_shadow #(.W(CNT_W), .ALWAYS_BUF(1'b0)) u_reload (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_reload),
      .wr_data (reg_wdata[CNT_W-1:0]),
      .buf_en  (arb),
      .upd_now (upd_now),
      .pre_q   (arr_pre),
      .sh_q    (arr_sh),
      .sh_next (arr_sh_next)
   );

   buf_timer_shadow #(.W(PSC_W), .ALWAYS_BUF(1'b1)) u_presc_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_presc),
      .wr_data (reg_wdata[PSC_W-1:0]),
      .buf_en  (1'b1),
      .upd_now (upd_now),
      .pre_q   (psc_pre),
      .sh_q    (psc_sh),
      .sh_next (psc_next_unused)
   );

   buf_timer_prescaler #(.W(PSC_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (run && tick_en),
      .clr     (ug_req),
      .div_sh  (psc_sh),
      .adv     (adv)
   );

   buf_timer_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .dir_down (dir_down),
      .clr      (ug_req),
      .lim      (arr_sh),
      .lim_next (arr_sh_next),
      .cnt_q    (cnt_q),
      .cnt_next (cnt_next),
      .wrap     (wrap)
   );

   // ---------------- compare channels ----------------
   logic [CNT_W-1:0]        cmp_pre [NUM_CH];
   logic [CNT_W-1:0]        cmp_sh  [NUM_CH];
   logic [NUM_CH*CNT_W-1:0] cmp_sh_flat;
   logic [NUM_CH-1:0]       hit_q;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic             wr_cmp;
      logic [CNT_W-1:0] pre_v, sh_v, sh_nx;

      assign wr_cmp = reg_we && (reg_addr == ADDR_W'(ADR_CMP_BASE + g));

      buf_timer_shadow #(.W(CNT_W), .ALWAYS_BUF(1'b0)) u_cmp (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_cmp),
         .wr_data (reg_wdata[CNT_W-1:0]),
         .buf_en  (chb[g]),
         .upd_now (upd_now),
         .pre_q   (pre_v),
         .sh_q    (sh_v),
         .sh_next (sh_nx)
      );

      assign cmp_pre[g] = pre_v;
      assign cmp_sh[g]  = sh_v;
      assign cmp_sh_flat[g*CNT_W +: CNT_W] = sh_v;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hit_q[g] <= 1'b0;
         else        hit_q[g] <= adv && (cnt_next == sh_nx);
      end
   end

   // ---------------- update pulse ----------------
   logic upd_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_q <= 1'b0;
      else        upd_q <= upd_now;
   end

   assign upd_evt = upd_q;
   assign cmp_hit = hit_q;

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADR_CTRL))   reg_rdata[CTRL_W-1:0] = ctrl_q;
      if (reg_addr == ADDR_W'(ADR_RELOAD)) reg_rdata[CNT_W-1:0]  = arr_pre;
      if (reg_addr == ADDR_W'(ADR_PRESC))  reg_rdata[PSC_W-1:0]  = psc_pre;
      if (reg_addr == ADDR_W'(ADR_COUNT))  reg_rdata[CNT_W-1:0]  = cnt_q;
      for (int i = 0; i < NUM_CH; i++) begin
         if (reg_addr == ADDR_W'(ADR_CMP_BASE + i)) reg_rdata[CNT_W-1:0] = cmp_pre[i];
      end
   end
endmodule

// File: rtl/buf_timer_chk.sv
module buf_timer_chk #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PSC_W  = 16,
   parameter int unsigned NUM_CH = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    tick_en,
   input logic                    run,
   input logic                    arb,
   input logic                    ug_req,
   input logic                    upd_now,
   input logic                    upd_evt,
   input logic [NUM_CH-1:0]       cmp_hit,
   input logic [CNT_W-1:0]        cnt_q,
   input logic [CNT_W-1:0]        arr_sh,
   input logic [PSC_W-1:0]        psc_sh,
   input logic [NUM_CH*CNT_W-1:0] cmp_sh_flat
);
   // R2: no stepping and no forced update means the counter holds
   a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!(run && tick_en) && !ug_req) |=> $stable(cnt_q));

   // R3 / R4: an update always lands on one of the two bounds
   a_r3_update_on_bound: assert property (@(posedge clk) disable iff (!rst_n)
      upd_evt |-> (cnt_q == '0 || cnt_q == arr_sh));

   // R6: buffered working reload moves only on an update
   a_r6_reload_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (arb && !upd_now) |=> $stable(arr_sh));

   // R7: working divisor moves only on an update
   a_r7_divisor_waits: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_now |=> $stable(psc_sh));

   // R9: a forced update is always seen on the output
   a_r9_force_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      ug_req |=> upd_evt);

   // R8: a hit coincides with the counter on the working compare value
   for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
      a_r8_hit_matches: assert property (@(posedge clk) disable iff (!rst_n)
         cmp_hit[g] |-> (cnt_q == cmp_sh_flat[g*CNT_W +: CNT_W]));
   end
endmodule

bind buf_timer buf_timer_chk #(
   .CNT_W  (CNT_W),
   .PSC_W  (PSC_W),
   .NUM_CH (NUM_CH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_en     (tick_en),
   .run         (run),
   .arb         (arb),
   .ug_req      (ug_req),
   .upd_now     (upd_now),
   .upd_evt     (upd_evt),
   .cmp_hit     (cmp_hit),
   .cnt_q       (cnt_q),
   .arr_sh      (arr_sh),
   .psc_sh      (psc_sh),
   .cmp_sh_flat (cmp_sh_flat)
);

// File: tb/buf_timer_tb.sv
module buf_timer_tb;
   localparam int DW = 16;
   localparam int AW = 3;
   localparam int NCH = 4;
   localparam int A_CTRL = 0, A_RLD = 1, A_PSC = 2, A_CNT = 3, A_CMP0 = 4;
   localparam int LIMIT = 2000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          tick_en = 1'b1;
   logic          dir_down = 1'b0;
   logic          upd_evt;
   logic [NCH-1:0] cmp_hit;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   buf_timer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .tick_en   (tick_en),
      .dir_down  (dir_down),
      .upd_evt   (upd_evt),
      .cmp_hit   (cmp_hit)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      reg_addr = AW'(a);
      #1;
      v = int'(reg_rdata);
   endtask

   task automatic wait_upd(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!upd_evt && n < LIMIT);
   endtask

   task automatic wait_hit(input int ch, output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!cmp_hit[ch] && n < LIMIT);
   endtask

   task automatic t_reset();
      int v;
      for (int a = 0; a < 8; a++) begin
         rd(a, v);
         check($sformatf("R1 reg %0d after reset", a), v, 0);
      end
      check("R1 upd_evt low", int'(upd_evt), 0);
      check("R1 cmp_hit low", int'(cmp_hit), 0);
      repeat (10) @(negedge clk);
      rd(A_CNT, v);
      check("R1 counter stopped without run", v, 0);
   endtask

   task automatic t_run_up();
      int v, n;
      wr(A_RLD, 5);          // buffer off: immediate
      wr(A_CTRL, 'h01);
      wait_upd(n);
      rd(A_CNT, v);
      check("R3 counter 0 at up wrap", v, 0);
      wait_upd(n);
      check("R5 R3 period with bound 5", n, 6);
   endtask

   task automatic t_reload_buf();
      int v, n;
      wr(A_CTRL, 'h03);
      wait_upd(n);
      wr(A_RLD, 9);
      rd(A_RLD, v);
      check("R10 reload reads holding value", v, 9);
      rd(A_CNT, v);
      check("R6 counter mid period", v, 2);
      wait_upd(n);
      check("R6 old bound kept until update", n, 4);
      wait_upd(n);
      check("R6 new bound after update", n, 10);
   endtask

   task automatic t_presc_buf();
      int v, n;
      wait_upd(n);
      wr(A_PSC, 2);
      rd(A_PSC, v);
      check("R10 prescale reads holding value", v, 2);
      wait_upd(n);
      check("R7 old divisor kept until update", n, 8);
      wait_upd(n);
      check("R7 R2 period with divisor 2", n, 30);
   endtask

   task automatic t_force();
      int v, n;
      wr(A_PSC, 0);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(A_CTRL); reg_wdata = DW'('h43);
      @(negedge clk);
      reg_we = 1'b0;
      check("R9 forced update pulse", int'(upd_evt), 1);
      rd(A_CNT, v);
      check("R9 counter cleared", v, 0);
      rd(A_CTRL, v);
      check("R10 force bit reads 0", v, 'h03);
      wait_upd(n);
      check("R9 divisor loaded by force", n, 10);
   endtask

   task automatic t_cmp_direct();
      int v, n;
      wr(A_CMP0, 4);
      wait_hit(0, n);
      rd(A_CNT, v);
      check("R8 ch0 hit at value 4", v, 4);
      @(negedge clk);
      check("R8 ch0 pulse one clock", int'(cmp_hit[0]), 0);
      wait_hit(0, n);
      check("R8 ch0 hit spacing", n, 9);
   endtask

   task automatic t_cmp_buf();
      int v, n;
      wr(A_CMP0 + 1, 3);     // ch1 buffer off: immediate
      wr(A_CTRL, 'h0B);      // run, reload buffer, ch1 buffer
      wait_upd(n);
      wr(A_CMP0 + 1, 7);
      wait_hit(1, n);
      rd(A_CNT, v);
      check("R8 ch1 old value before update", v, 3);
      wait_upd(n);
      wait_hit(1, n);
      rd(A_CNT, v);
      check("R8 ch1 new value after update", v, 7);
   endtask

   task automatic t_down();
      int v, n;
      wr(A_CTRL, 'h01);
      @(negedge clk);
      dir_down = 1'b1;
      wr(A_RLD, 3);
      wait_upd(n);
      rd(A_CNT, v);
      check("R4 counter reloads at down wrap", v, 3);
      wait_upd(n);
      check("R4 down period with bound 3", n, 4);
   endtask

   task automatic t_hold();
      int v1, v2, seen;
      @(negedge clk);
      tick_en = 1'b0;
      rd(A_CNT, v1);
      seen = 0;
      repeat (20) begin @(negedge clk); if (upd_evt) seen++; end
      rd(A_CNT, v2);
      check("R2 hold with tick_en low", v2, v1);
      check("R2 no update with tick_en low", seen, 0);
      tick_en = 1'b1;
      wr(A_CTRL, 'h00);
      rd(A_CNT, v1);
      repeat (20) @(negedge clk);
      rd(A_CNT, v2);
      check("R2 hold with run clear", v2, v1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_run_up();
      t_reload_buf();
      t_presc_buf();
      t_force();
      t_cmp_direct();
      t_cmp_buf();
      t_down();
      t_hold();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule